// File: doc/BRIEF.md
# SPI Flash Transfer Engine

A register-driven SPI master for one serial flash device. Software fills a 64-byte data buffer through a 32-bit register port, programs how many bits to move, and sets a start bit. The engine clocks the buffer out on a single data line, most significant bit of byte 0 first. When capture is enabled, it writes the input line back into the same buffer positions as the bits leave. At the end it sets a done flag.

Serial clock timing comes from an external enable tick. Each tick advances SCK by one half-period. A chip-select keep control leaves CS_n asserted after a transfer. Several buffer-sized chunks can then be joined into one flash command frame. A software reset bit aborts a transfer at any point.

Top module: `flash_xfer_eng`

## Requirements
- R1: After reset, cs_no is 1, sck_o and mosi_o are 0, and the busy bit (bit 18 at 0x00) and the done flag (bit 4 at 0x30) read 0.
- R2: Writing 1 to bit 18 at 0x00 starts a transfer. That bit reads 1 while the transfer runs and returns to 0 by itself when it ends.
- R3: Bits leave MSB-first in byte order. Byte k sits in bits 8*(k%4)+7:8*(k%4) of the word at 0x40+4*(k/4). mosi_o changes only while sck_o is low, and holds steady through every high phase.
- R4: The field at bits 25:17 of 0x20 holds the bit count minus one. A transfer produces exactly that many plus one rising SCK edges, from 1 up to 512.
- R5: When bit 0 of 0x1C is 1, miso_i is sampled on each rising SCK edge and written over the buffer bit just sent. When it is 0, the buffer is left unchanged.
- R6: The done flag (bit 4 at 0x30) is set when the last bit completes. Writing 0 to it clears it. If the set and a clearing write fall in the same clock, the set wins.
- R7: When bit 30 of 0x2C is 1, cs_no stays low after the transfer. A following transfer then continues the same frame without releasing CS. When it is 0, cs_no goes high at the end.
- R8: cs_no goes low at least two ticks (one SCK period) before the first rising edge. With keep clear, it is released exactly one tick after the last falling edge. sck_o is high only while cs_no is low.
- R9: A start written while a transfer runs is ignored, and so is a buffer write during a transfer.
- R10: Writing 1 to bit 31 at 0x30 aborts any transfer: SCK low, cs_no high, busy and done cleared. The bit reads 0.
- R11: Bit 30 at 0x30 is the operating mode and reads back as written. A start is accepted only when it is 0 (master).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 7 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| sck_tick_i | input | 1 | SCK half-period enable tick |
| sck_o | output | 1 | Serial clock, idle low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Two events can land on the same clock edge. One is the engine setting the done flag as its tail phase ends. The other is software writing 0 to the status register to clear it. With the tick held high, the end of an N-bit transfer falls exactly 3+2N clocks after the start write, so the bench places the clearing write on that edge. The flag must then read 1, and a later clearing write must bring it to 0.

// File: rtl/flash_xfer_pkg.sv
package flash_xfer_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned OFS_CMD   = 'h00;
  localparam int unsigned OFS_USER  = 'h1C;
  localparam int unsigned OFS_LEN   = 'h20;
  localparam int unsigned OFS_CSCTL = 'h2C;
  localparam int unsigned OFS_CTRL  = 'h30;
  localparam int unsigned MIN_BUF_BASE = 'h40;

  localparam int unsigned START_BIT = 18;
  localparam int unsigned CAP_BIT   = 0;
  localparam int unsigned LEN_LSB   = 17;
  localparam int unsigned KEEP_BIT  = 30;
  localparam int unsigned DONE_BIT  = 4;
  localparam int unsigned MODE_BIT  = 30;
  localparam int unsigned SRST_BIT  = 31;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_SHIFT,
    SEQ_TAIL
  } seq_state_e;
endpackage

// File: rtl/flash_xfer_buf.sv
module flash_xfer_buf #(
  parameter int unsigned BYTES = 64,
  localparam int unsigned WORDS  = BYTES / 4,
  localparam int unsigned WIDX_W = $clog2(WORDS),
  localparam int unsigned BIT_W  = $clog2(BYTES * 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDX_W-1:0] wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic [WIDX_W-1:0] rd_idx_i,
  output logic [31:0]       rd_data_o,
  input  logic              bit_we_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  input  logic [BIT_W-1:0]  tx_idx_i,
  output logic              tx_bit_o
);
  logic [BYTES*8-1:0] mem_q;

  // serial bit n -> byte n/8, bit 7-(n%8)
  function automatic logic [BIT_W-1:0] flat_pos(input logic [BIT_W-1:0] n);
    return {n[BIT_W-1:3], 3'd7 - n[2:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      if (wr_en_i) mem_q[{wr_idx_i, 5'd0} +: 32] <= wr_data_i;
      if (bit_we_i) mem_q[flat_pos(bit_idx_i)] <= bit_val_i;
    end
  end

  assign rd_data_o = mem_q[{rd_idx_i, 5'd0} +: 32];
  assign tx_bit_o  = mem_q[flat_pos(tx_idx_i)];
endmodule

// File: rtl/flash_xfer_seq.sv
module flash_xfer_seq
  import flash_xfer_pkg::*;
#(
  parameter int unsigned BIT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [BIT_W-1:0] last_idx_i,
  input  logic             keep_i,
  input  logic             cap_en_i,
  input  logic             miso_i,
  input  logic             tx_bit_i,
  output logic [BIT_W-1:0] tx_idx_o,
  output logic             cap_we_o,
  output logic [BIT_W-1:0] cap_idx_o,
  output logic             cap_bit_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_set_o
);
  seq_state_e       state_q;
  logic             lead_q, sck_q, cs_n_q, mosi_q;
  logic [BIT_W-1:0] idx_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      lead_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
    end else if (srst_i) begin
      state_q <= SEQ_IDLE;
      lead_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_LEAD;
          cs_n_q  <= 1'b0;
          idx_q   <= '0;
          lead_q  <= 1'b0;
          last_q  <= last_idx_i;
          mosi_q  <= tx_bit_i;  // first bit presented before any edge
        end
        SEQ_LEAD: if (tick_i) begin
          if (lead_q) state_q <= SEQ_SHIFT;
          lead_q <= 1'b1;
        end
        SEQ_SHIFT: if (tick_i) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            if (idx_q == last_q) begin
              state_q <= SEQ_TAIL;
            end else begin
              idx_q  <= idx_q + BIT_W'(1);
              mosi_q <= tx_bit_i;
            end
          end
        end
        SEQ_TAIL: if (tick_i) begin
          state_q <= SEQ_IDLE;
          cs_n_q  <= ~keep_i;
          mosi_q  <= 1'b0;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != SEQ_IDLE);
  assign tx_idx_o   = busy_o ? idx_q + BIT_W'(1) : '0;
  assign cap_we_o   = (state_q == SEQ_SHIFT) && tick_i && !sck_q && cap_en_i && !srst_i;
  assign cap_idx_o  = idx_q;
  assign cap_bit_o  = miso_i;
  assign done_set_o = (state_q == SEQ_TAIL) && tick_i && !srst_i;
  assign sck_o      = sck_q;
  assign cs_no      = cs_n_q;
  assign mosi_o     = mosi_q;
endmodule

// File: rtl/flash_xfer_eng.sv
module flash_xfer_eng
  import flash_xfer_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned BUF_BASE = (BUF_BYTES > MIN_BUF_BASE) ? BUF_BYTES : MIN_BUF_BASE,
  localparam int unsigned ADDR_W   = $clog2(BUF_BASE * 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              sck_tick_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned WORDS  = BUF_BYTES / 4;
  localparam int unsigned WIDX_W = $clog2(WORDS);
  localparam int unsigned BIT_W  = $clog2(BUF_BYTES * 8);

  logic             cap_en_q, keep_q, mode_q, done_q;
  logic [BIT_W-1:0] len_q;
  logic             busy, done_set, srst, start, buf_we;
  logic             cap_we, cap_bit, tx_bit;
  logic [BIT_W-1:0] tx_idx, cap_idx;
  logic [31:0]      buf_rdata;
  logic             hit_cmd, hit_user, hit_len, hit_csctl, hit_ctrl, hit_buf;

  assign hit_cmd   = reg_addr_i == ADDR_W'(OFS_CMD);
  assign hit_user  = reg_addr_i == ADDR_W'(OFS_USER);
  assign hit_len   = reg_addr_i == ADDR_W'(OFS_LEN);
  assign hit_csctl = reg_addr_i == ADDR_W'(OFS_CSCTL);
  assign hit_ctrl  = reg_addr_i == ADDR_W'(OFS_CTRL);
  assign hit_buf   = reg_addr_i >= ADDR_W'(BUF_BASE);

  assign srst   = reg_we_i && hit_ctrl && reg_wdata_i[SRST_BIT];
  assign start  = reg_we_i && hit_cmd && reg_wdata_i[START_BIT] && !mode_q;
  assign buf_we = reg_we_i && hit_buf && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_en_q <= 1'b0;
      keep_q   <= 1'b0;
      mode_q   <= 1'b0;
      done_q   <= 1'b0;
      len_q    <= '0;
    end else begin
      if (reg_we_i && hit_user)  cap_en_q <= reg_wdata_i[CAP_BIT];
      if (reg_we_i && hit_len)   len_q    <= reg_wdata_i[LEN_LSB +: BIT_W];
      if (reg_we_i && hit_csctl) keep_q   <= reg_wdata_i[KEEP_BIT];
      if (reg_we_i && hit_ctrl)  mode_q   <= reg_wdata_i[MODE_BIT];
      // engine set outranks a same-cycle software clear
      if (srst)                          done_q <= 1'b0;
      else if (done_set)                 done_q <= 1'b1;
      else if (reg_we_i && hit_ctrl)     done_q <= done_q & reg_wdata_i[DONE_BIT];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit_buf) begin
      reg_rdata_o = buf_rdata;
    end else if (hit_cmd) begin
      reg_rdata_o[START_BIT] = busy;
    end else if (hit_user) begin
      reg_rdata_o[CAP_BIT] = cap_en_q;
    end else if (hit_len) begin
      reg_rdata_o[LEN_LSB +: BIT_W] = len_q;
    end else if (hit_csctl) begin
      reg_rdata_o[KEEP_BIT] = keep_q;
    end else if (hit_ctrl) begin
      reg_rdata_o[DONE_BIT] = done_q;
      reg_rdata_o[MODE_BIT] = mode_q;
    end
  end

  flash_xfer_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (buf_we),
    .wr_idx_i  (reg_addr_i[WIDX_W+1:2]),
    .wr_data_i (reg_wdata_i),
    .rd_idx_i  (reg_addr_i[WIDX_W+1:2]),
    .rd_data_o (buf_rdata),
    .bit_we_i  (cap_we),
    .bit_idx_i (cap_idx),
    .bit_val_i (cap_bit),
    .tx_idx_i  (tx_idx),
    .tx_bit_o  (tx_bit)
  );

  flash_xfer_seq #(.BIT_W(BIT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst),
    .tick_i     (sck_tick_i),
    .start_i    (start),
    .last_idx_i (len_q),
    .keep_i     (keep_q),
    .cap_en_i   (cap_en_q),
    .miso_i     (miso_i),
    .tx_bit_i   (tx_bit),
    .tx_idx_o   (tx_idx),
    .cap_we_o   (cap_we),
    .cap_idx_o  (cap_idx),
    .cap_bit_o  (cap_bit),
    .sck_o      (sck_o),
    .cs_no      (cs_no),
    .mosi_o     (mosi_o),
    .busy_o     (busy),
    .done_set_o (done_set)
  );
endmodule

// File: rtl/flash_xfer_chk.sv
module flash_xfer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic cs_n_i,
  input logic mosi_i,
  input logic busy_i,
  input logic done_i,
  input logic srst_i
);
  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i && $past(sck_i)) |-> $stable(mosi_i));

  // R8
  sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |-> (!cs_n_i && busy_i));

  // R6
  done_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !$past(srst_i)) |-> done_i);

  // R10
  srst_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_i) |-> (!busy_i && cs_n_i && !sck_i && !done_i));

  // R2
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i)) |-> $stable(cs_n_i));
endmodule

bind flash_xfer_eng flash_xfer_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sck_i  (sck_o),
  .cs_n_i (cs_no),
  .mosi_i (mosi_o),
  .busy_i (busy),
  .done_i (done_q),
  .srst_i (srst)
);

// File: tb/flash_xfer_eng_test.sv
`timescale 1ns/1ps
module flash_xfer_eng_test;
  logic        clk = 0, rst_n = 0;
  logic [6:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0, rdata;
  logic        tick = 0;
  logic        sck, cs_n, mosi, miso;

  int errors = 0, checks = 0;
  int tdiv = 1, tcnt = 0;
  int rises = 0, falls = 0, glitch = 0, cs_rises = 0;
  logic [512:0] pat = '0;
  logic [511:0] seen = '0;
  logic [7:0]   sbuf [64];
  time t_csf, t_rise1, t_lastf, t_csr;
  logic prev_sck = 0, prev_mosi = 0;

  always #2.5 clk = ~clk;

  flash_xfer_eng uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_tick_i(tick),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % tdiv;
    tick = (tcnt == 0);
    if (sck && prev_sck && mosi !== prev_mosi) glitch++;
    prev_sck = sck;
    prev_mosi = mosi;
  end

  // flash-side model
  assign miso = pat[falls];
  always @(posedge sck) begin
    if (rises < 512) seen[rises] = mosi;
    if (rises == 0) t_rise1 = $time;
    rises++;
  end
  always @(negedge sck) begin falls++; t_lastf = $time; end
  always @(negedge cs_n) t_csf = $time;
  always @(posedge cs_n) begin t_csr = $time; cs_rises++; end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic load_buf();
    for (int w = 0; w < 16; w++)
      wr(7'h40 + 7'(4*w), {sbuf[4*w+3], sbuf[4*w+2], sbuf[4*w+1], sbuf[4*w]});
  endtask

  task automatic clear_model();
    rises = 0; falls = 0; glitch = 0; seen = '0;
  endtask

  task automatic setup(input int nbits, input logic cap, input logic keep);
    wr(7'h1C, {31'd0, cap});
    wr(7'h20, 32'(nbits - 1) << 17);
    wr(7'h2C, {1'b0, keep, 30'd0});
    wr(7'h30, 32'd0);
    clear_model();
  endtask

  task automatic wait_done();
    logic [31:0] d;
    do rd(7'h00, d); while (d[18]);
  endtask

  task automatic absorb(input int nbits, input logic cap);
    if (cap) for (int i = 0; i < nbits; i++) sbuf[i/8][7-(i%8)] = pat[i];
  endtask

  function automatic int tx_mismatch(input int nbits);
    int m = 0;
    for (int i = 0; i < nbits; i++) if (seen[i] !== sbuf[i/8][7-(i%8)]) m++;
    return m;
  endfunction

  task automatic check_buf(input string tag);
    logic [31:0] d;
    int m = 0;
    for (int w = 0; w < 16; w++) begin
      rd(7'h40 + 7'(4*w), d);
      if (d !== {sbuf[4*w+3], sbuf[4*w+2], sbuf[4*w+1], sbuf[4*w]}) m++;
    end
    chk(m == 0, tag, m, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(cs_n === 1 && sck === 0 && mosi === 0, "R1 pins", {cs_n, sck, mosi}, 3'b100);
    rd(7'h00, d); chk(d === 0, "R1 busy", d, 0);
    rd(7'h30, d); chk(d === 0, "R1 done", d, 0);
  endtask

  task automatic t_duplex();
    logic [31:0] d;
    tdiv = 1;
    for (int i = 0; i < 64; i++) sbuf[i] = 8'(i * 37 + 5);
    sbuf[0] = 8'h81; sbuf[1] = 8'h42;
    load_buf();
    for (int i = 0; i < 513; i++) pat[i] = ((i * 7) % 5) < 2;
    setup(32, 1, 0);
    wr(7'h00, 32'd1 << 18);
    rd(7'h00, d); chk(d[18] === 1, "R2 busy while running", d[18], 1);
    wait_done();
    chk(rises == 32, "R4 edge count 32", rises, 32);
    chk(tx_mismatch(32) == 0, "R3 mosi order", tx_mismatch(32), 0);
    chk(glitch == 0, "R3 mosi stable in high phase", glitch, 0);
    chk(t_rise1 - t_csf >= 10, "R8 lead", t_rise1 - t_csf, 15);
    chk(t_csr - t_lastf == 5, "R8 tail", t_csr - t_lastf, 5);
    chk(cs_n === 1, "R7 release", cs_n, 1);
    rd(7'h30, d); chk(d[4] === 1, "R6 done set", d[4], 1);
    rd(7'h00, d); chk(d[18] === 0, "R2 self clear", d[18], 0);
    absorb(32, 1);
    check_buf("R5 capture into buffer");
  endtask

  task automatic t_keep();
    logic [31:0] d;
    int r0;
    tdiv = 3;
    for (int i = 0; i < 513; i++) pat[i] = i[0];
    setup(12, 0, 1);
    r0 = cs_rises;
    wr(7'h00, 32'd1 << 18);
    wait_done();
    chk(rises == 12, "R4 edge count 12", rises, 12);
    chk(tx_mismatch(12) == 0, "R3 mosi order odd length", tx_mismatch(12), 0);
    chk(cs_n === 0, "R7 keep holds cs", cs_n, 0);
    check_buf("R5 no capture when disabled");
    setup(8, 0, 0);
    wr(7'h00, 32'd1 << 18);
    wait_done();
    chk(rises == 8, "R4 edge count 8", rises, 8);
    chk(cs_rises - r0 == 1 && cs_n === 1, "R7 single frame", cs_rises - r0, 1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    tdiv = 2;
    setup(16, 0, 0);
    wr(7'h00, 32'd1 << 18);
    repeat (10) @(posedge clk);
    wr(7'h40, 32'hDEADBEEF);
    wr(7'h00, 32'd1 << 18);
    wait_done();
    repeat (6) @(posedge clk);
    rd(7'h00, d);
    chk(rises == 16 && d[18] === 0, "R9 restart ignored", rises, 16);
    check_buf("R9 buffer write ignored");
  endtask

  task automatic t_done_race();
    logic [31:0] d;
    tdiv = 1;
    setup(4, 0, 0);
    wr(7'h00, 32'd1 << 18);
    repeat (2 + 2*4) @(posedge clk);
    wr(7'h30, 32'd0);  // lands on the done-set edge
    rd(7'h30, d); chk(d[4] === 1, "R6 set beats clear", d[4], 1);
    wr(7'h30, 32'd0);
    rd(7'h30, d); chk(d[4] === 0, "R6 clear", d[4], 0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    tdiv = 1;
    setup(64, 0, 1);
    wr(7'h00, 32'd1 << 18);
    repeat (20) @(posedge clk);
    wr(7'h30, 32'd1 << 31);
    chk(cs_n === 1 && sck === 0, "R10 pins after abort", {cs_n, sck}, 2'b10);
    rd(7'h00, d); chk(d[18] === 0, "R10 busy cleared", d[18], 0);
    rd(7'h30, d); chk(d === 0, "R10 status cleared", d, 0);
    setup(8, 0, 0);
    wr(7'h00, 32'd1 << 18);
    wait_done();
    chk(rises == 8, "R10 usable after abort", rises, 8);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(7'h30, 32'd1 << 30);
    rd(7'h30, d); chk(d[30] === 1, "R11 mode readback", d[30], 1);
    clear_model();
    wr(7'h00, 32'd1 << 18);
    repeat (8) @(posedge clk);
    rd(7'h00, d);
    chk(d[18] === 0 && cs_n === 1 && rises == 0, "R11 start blocked", d[18], 0);
    wr(7'h30, 32'd0);
  endtask

  task automatic t_full();
    tdiv = 1;
    for (int i = 0; i < 64; i++) sbuf[i] = 8'($urandom);
    load_buf();
    for (int i = 0; i < 513; i++) pat[i] = 1'($urandom);
    setup(512, 1, 0);
    wr(7'h00, 32'd1 << 18);
    wait_done();
    chk(rises == 512, "R4 edge count 512", rises, 512);
    chk(tx_mismatch(512) == 0, "R3 mosi order full", tx_mismatch(512), 0);
    absorb(512, 1);
    check_buf("R5 full capture");
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) sbuf[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_duplex();
    t_keep();
    t_busy_ignore();
    t_done_race();
    t_srst();
    t_mode();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule